// File: doc/BRIEF.md
# Thermal Clock-Throttle Duty Generator

This block drives a periodic stop-clock request that slows a processor when it must shed heat. Time is cut into fixed windows of 1024 cycles of the bus clock. In each window the request is held high for a number of cycles set by a 3-bit duty code, and low for the rest of the window. The duty code may be written only once after reset. Throttling has two sources. A force bit starts it at once. A thermal alarm input starts it only after the alarm has stayed active for a qualification time. That time is counted in pulses of a slow tick input, so a bench can shorten it.

Throttling only takes place while the processor reports the full-power running state. In any other state, including the deeper stop-grant sleep state, the request stays low. A status output shows when throttling is in progress.

Top module: `thermal_throttle_gen`

## Requirements
- R1: While throttling, `stpclk_o` repeats with a period of 1024 cycles. It is high for the first H cycles of each window and low for the other 1024-H cycles.
- R2: H depends on the duty code: 0→512, 1→896, 2→768, 3→640, 4→512, 5→384, 6→256, 7→128.
- R3: The first pulse on `duty_we_i` after reset loads `duty_i` into the duty code. Every later pulse is ignored until reset. `duty_o` shows the code from the cycle after the write.
- R4: The force bit can be written at any time, and `force_o` shows it. When the force bit is 1 and `in_c0_i` is 1, `stpclk_o` goes high on the second rising edge after the write is sampled, with no qualification delay.
- R5: The alarm causes throttling only after `alarm_i` has stayed high through QUAL_TICKS pulses of `tick_i`. Any low cycle on `alarm_i` clears the count. Throttling stops two edges after the alarm drops, unless the force bit holds it.
- R6: The alarm path has no enable. A qualified alarm throttles even when the force bit is 0.
- R7: When `in_c0_i` is low, `stpclk_o` and `throttling_o` are 0 from the next edge onward. When it returns high, a fresh window starts.
- R8: `throttling_o` is 1 whenever the block is throttling, and 0 otherwise. `stpclk_o` is never high while `throttling_o` is low.
- R9: A duty code written during throttling takes effect at the next window boundary. The current window keeps its count.
- R10: After reset, `stpclk_o`, `throttling_o`, `duty_o` and `force_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| duty_we_i | input | 1 | Write strobe for the duty code |
| duty_i | input | 3 | Duty code write data |
| force_we_i | input | 1 | Write strobe for the force bit |
| force_i | input | 1 | Force bit write data |
| alarm_i | input | 1 | Thermal alarm, active high |
| tick_i | input | 1 | Slow qualification tick, one-cycle pulse |
| in_c0_i | input | 1 | Processor is in the full-power running state |
| duty_o | output | 3 | Duty code readback |
| force_o | output | 1 | Force bit readback |
| throttling_o | output | 1 | Throttle status |
| stpclk_o | output | 1 | Stop-clock request |

## Verification
A window counter or latched limit that has drifted would show up within one 1024-cycle window. The high count would be wrong, or the high cycles would not be one contiguous run at the window start. A broken lock would change `duty_o` on the cycle after a second write. A wrong qualification count would make `throttling_o` rise one tick too early or too late, which shows up within a few cycles of the deciding tick. Gating faults would show on `stpclk_o` on the edge after `in_c0_i` falls.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int unsigned DUTY_W = 3;

  // High-cycle count for a code: code 0 means half the window, code n means (8-n)/8 of it.
  function automatic int unsigned thr_high_count(logic [DUTY_W-1:0] code, int unsigned win_w);
    int unsigned eighths;
    eighths = (code == '0) ? 32'd4 : (32'd8 - 32'(code));
    return eighths << (win_w - 3);
  endfunction
endpackage

// File: rtl/thr_ctrl_reg.sv
module thr_ctrl_reg
  import thr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              duty_we_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              force_we_i,
  input  logic              force_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              force_o
);
  logic [DUTY_W-1:0] duty_q;
  logic              locked_q;
  logic              force_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q   <= '0;
      locked_q <= 1'b0;
      force_q  <= 1'b0;
    end else begin
      if (duty_we_i && !locked_q) begin
        duty_q   <= duty_i;
        locked_q <= 1'b1;
      end
      if (force_we_i) force_q <= force_i;
    end
  end

  assign duty_o  = duty_q;
  assign force_o = force_q;

  AST_DUTY_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> $stable(duty_q)); // R3
  AST_FORCE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_we_i |=> (force_q == $past(force_i))); // R4
endmodule

// File: rtl/thr_alarm_qual.sv
module thr_alarm_qual #(
  parameter int unsigned QUAL_TICKS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alarm_i,
  input  logic tick_i,
  output logic qualified_o
);
  localparam int unsigned QW = $clog2(QUAL_TICKS + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_TICKS);

  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!alarm_i)                cnt_q <= '0;
    else if (tick_i && cnt_q != QMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign qualified_o = (cnt_q == QMAX);

  AST_QUAL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= QMAX); // R5
  AST_QUAL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qualified_o |-> $past(alarm_i)); // R5
endmodule

// File: rtl/thr_duty_gen.sv
module thr_duty_gen
  import thr_pkg::*;
#(
  parameter int unsigned WIN_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              stpclk_o,
  output logic              busy_o
);
  logic [WIN_W-1:0] win_cnt_q;
  logic [WIN_W-1:0] lim_q;
  logic [WIN_W-1:0] lim_now;
  logic             stpclk_q;
  logic             busy_q;

  // Limit sampled only at window start, so a new code waits for the boundary.
  assign lim_now = (win_cnt_q == '0) ? WIN_W'(thr_high_count(duty_i, WIN_W)) : lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt_q <= '0;
      lim_q     <= '0;
      stpclk_q  <= 1'b0;
      busy_q    <= 1'b0;
    end else if (!active_i) begin
      win_cnt_q <= '0;
      stpclk_q  <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      win_cnt_q <= win_cnt_q + 1'b1;
      stpclk_q  <= (win_cnt_q < lim_now);
      busy_q    <= 1'b1;
      if (win_cnt_q == '0) lim_q <= lim_now;
    end
  end

  assign stpclk_o = stpclk_q;
  assign busy_o   = busy_q;

  AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stpclk_q) |-> (win_cnt_q == WIN_W'(1))); // R1
  AST_FALL_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(stpclk_q) && busy_q) |-> (win_cnt_q == lim_q + 1'b1)); // R1
endmodule

// File: rtl/thermal_throttle_gen.sv
module thermal_throttle_gen
  import thr_pkg::*;
#(
  parameter int unsigned WIN_W      = 10,
  parameter int unsigned QUAL_TICKS = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              duty_we_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              force_we_i,
  input  logic              force_i,
  input  logic              alarm_i,
  input  logic              tick_i,
  input  logic              in_c0_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              force_o,
  output logic              throttling_o,
  output logic              stpclk_o
);
  logic [DUTY_W-1:0] duty_code;
  logic              force_bit;
  logic              alarm_ok;
  logic              active;

  thr_ctrl_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .duty_we_i  (duty_we_i),
    .duty_i     (duty_i),
    .force_we_i (force_we_i),
    .force_i    (force_i),
    .duty_o     (duty_code),
    .force_o    (force_bit)
  );

  thr_alarm_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alarm_i     (alarm_i),
    .tick_i      (tick_i),
    .qualified_o (alarm_ok)
  );

  assign active = (force_bit | alarm_ok) & in_c0_i;

  thr_duty_gen #(.WIN_W(WIN_W)) u_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .duty_i   (duty_code),
    .stpclk_o (stpclk_o),
    .busy_o   (throttling_o)
  );

  assign duty_o  = duty_code;
  assign force_o = force_bit;

  AST_C0_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(in_c0_i) |-> !stpclk_o); // R7
  AST_STATUS_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stpclk_o |-> throttling_o); // R8
endmodule

// File: tb/tb_thermal_throttle_gen.sv
module tb_thermal_throttle_gen;
  localparam int unsigned QT = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       duty_we_i = 1'b0;
  logic [2:0] duty_i = '0;
  logic       force_we_i = 1'b0;
  logic       force_i = 1'b0;
  logic       alarm_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       in_c0_i = 1'b1;
  logic [2:0] duty_o;
  logic       force_o, throttling_o, stpclk_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  thermal_throttle_gen #(.WIN_W(10), .QUAL_TICKS(QT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .duty_we_i(duty_we_i), .duty_i(duty_i),
    .force_we_i(force_we_i), .force_i(force_i), .alarm_i(alarm_i), .tick_i(tick_i),
    .in_c0_i(in_c0_i), .duty_o(duty_o), .force_o(force_o),
    .throttling_o(throttling_o), .stpclk_o(stpclk_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_high(input int code);
    return (code == 0) ? 512 : (8 - code) * 128;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; duty_we_i = 0; force_we_i = 0; alarm_i = 0; tick_i = 0; in_c0_i = 1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wr_duty(input int code);
    @(negedge clk); duty_we_i = 1'b1; duty_i = 3'(code);
    @(negedge clk); duty_we_i = 1'b0;
  endtask

  task automatic wr_force(input bit v);
    @(negedge clk); force_we_i = 1'b1; force_i = v;
    @(negedge clk); force_we_i = 1'b0;
  endtask

  task automatic pulse_tick();
    repeat (5) @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  // Samples 1024 negedges; first sample is the next negedge.
  task automatic sample_window(input int exp_h, input string req);
    int highs = 0;
    int misplaced = 0;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      if (stpclk_o) highs++;
      if (stpclk_o != (i < exp_h)) misplaced++;
    end
    check(highs == exp_h, {req, " high count"}, highs, exp_h);
    check(misplaced == 0, {req, " contiguous from window start"}, misplaced, 0);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    // R10 reset state
    check(stpclk_o == 0 && throttling_o == 0, "R10 outputs idle", int'(stpclk_o), 0);
    check(duty_o == 0 && force_o == 0, "R10 register defaults", int'(duty_o), 0);

    // R1 R2 R3 R4 sweep over every duty code
    for (int code = 0; code < 8; code++) begin
      do_reset();
      wr_duty(code);
      check(duty_o == 3'(code), "R3 first write loads", int'(duty_o), code);
      wr_duty(code ^ 7);
      check(duty_o == 3'(code), "R3 second write ignored", int'(duty_o), code);
      wr_force(1'b1);
      check(force_o == 1'b1, "R4 force readback", int'(force_o), 1);
      check(stpclk_o == 1'b0, "R4 not yet high one edge after write", int'(stpclk_o), 0);
      sample_window(exp_high(code), "R2 window one");
      sample_window(exp_high(code), "R1 window two");
      check(throttling_o == 1'b1, "R8 status while forced", int'(throttling_o), 1);
    end

    // R4 force clear stops throttling
    wr_force(1'b0);
    @(negedge clk);
    check(stpclk_o == 0 && throttling_o == 0, "R4 force clear stops", int'(throttling_o), 0);

    // R9 duty change waits for the boundary
    do_reset();
    wr_force(1'b1);
    begin
      int h0 = 0;
      int h1 = 0;
      for (int i = 0; i < 2048; i++) begin
        @(negedge clk);
        if (stpclk_o) begin
          if (i < 1024) h0++; else h1++;
        end
        if (i == 100) begin duty_we_i = 1'b1; duty_i = 3'd7; end
        if (i == 101) duty_we_i = 1'b0;
      end
      check(h0 == 512, "R9 current window keeps count", h0, 512);
      check(h1 == 128, "R9 next window uses new code", h1, 128);
    end

    // R5 R6 alarm qualification
    do_reset();
    alarm_i = 1'b1;
    pulse_tick(); pulse_tick();
    @(negedge clk); alarm_i = 1'b0;
    @(negedge clk); alarm_i = 1'b1;
    pulse_tick(); pulse_tick();
    repeat (20) @(negedge clk);
    check(throttling_o == 1'b0, "R5 drop clears count", int'(throttling_o), 0);
    pulse_tick();
    check(stpclk_o == 1'b0, "R5 not high before qualified edge", int'(stpclk_o), 0);
    sample_window(512, "R6 alarm throttle without force");
    check(force_o == 1'b0 && throttling_o == 1'b1, "R6 throttling with force 0",
          int'(throttling_o), 1);
    @(negedge clk); alarm_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(throttling_o == 1'b0 && stpclk_o == 1'b0, "R5 alarm drop stops", int'(throttling_o), 0);

    // R7 C0 gating
    do_reset();
    in_c0_i = 1'b0;
    wr_duty(6);
    wr_force(1'b1);
    begin
      int bad = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (stpclk_o || throttling_o) bad++;
      end
      check(bad == 0, "R7 no throttle outside C0", bad, 0);
    end
    in_c0_i = 1'b1;
    sample_window(256, "R7 fresh window on return to C0");
    @(negedge clk); in_c0_i = 1'b0;
    @(negedge clk);
    check(stpclk_o == 0 && throttling_o == 0, "R7 leave C0 stops", int'(stpclk_o), 0);
    in_c0_i = 1'b1;
    sample_window(256, "R7 restart after gap");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule